// File: doc/BRIEF.md
# Zero-Terminated Text Upcasing Walker

The block walks a byte string held in memory and rewrites it in upper case where it lies. A start pulse loads a base address; from there the engine fetches one byte per step over a byte-wide synchronous memory port. The port uses a request/ready handshake. When a fetched byte is a lowercase ASCII letter, the engine stores it back with bit 5 cleared. Every other byte is left untouched and is never written.

The walk ends on the first byte that reads as zero. The engine then raises a done flag together with the number of bytes it examined, with the terminator counted. The flag stays up until the next start pulse. A start pulse that arrives while a walk is running has no effect.

Top module: `str_upcase`

## Requirements
- R1: After reset, done_o, mem_req_o and mem_we_o are low and count_o is zero.
- R2: On start_i while idle, the engine reads from base_i, then from base_i+1, base_i+2 and so on. The address advances by one after every byte, whether or not a write took place.
- R3: A read byte in the range 0x61 to 0x7A is written back to the same address as the byte AND 0xDF.
- R4: A read byte outside 0x61..0x7A is never written. This includes 0x60, 0x7B, digits, uppercase letters and bytes with bit 7 set.
- R5: A read byte equal to 0x00 ends the walk, and the terminator is never written. An empty string therefore produces no write at all.
- R6: At the end of a walk, count_o equals the number of bytes read, terminator included.
- R7: done_o stays high from the end of a walk until the next start_i.
- R8: start_i is ignored while a walk is in progress.
- R9: While mem_req_o is high and mem_rdy_i is low, mem_addr_o, mem_we_o and mem_wdata_o hold stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; samples base_i |
| base_i | input | AW | Address of the first byte |
| done_o | output | 1 | Walk complete, held until next start |
| count_o | output | CW | Bytes examined, terminator included |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid with mem_rdy_i on a read |
| mem_rdy_i | input | 1 | Access completes this cycle |

## Verification
A corrupted address register would show up on the very next request as a wrong address, and the bench model memory flags it on the spot. A wrong decision in the compare stage would show as a stray write or a missing write. The bench catches that through a per-cycle write log and a final comparison against the expected image. A bad state transition shows either as done rising at the wrong point or as a count that does not match the string length. The bench sweeps all 256 byte values, adds random ready stalls, and checks all of these effects.

// File: rtl/str_upcase_pkg.sv
package str_upcase_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_CHECK = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } state_e;

  localparam logic [7:0] LOW_A   = 8'h61;
  localparam logic [7:0] LOW_Z   = 8'h7A;
  localparam logic [7:0] UP_MASK = 8'hDF;
endpackage

// File: rtl/str_upcase_classify.sv
module str_upcase_classify
  import str_upcase_pkg::*;
(
  input  logic [7:0] byte_i,
  output logic       is_term_o,
  output logic       is_lower_o,
  output logic [7:0] upper_o
);
  assign is_term_o  = (byte_i == 8'h00);
  assign is_lower_o = (byte_i >= LOW_A) && (byte_i <= LOW_Z);
  assign upper_o    = byte_i & UP_MASK;
endmodule

// File: rtl/str_upcase_fsm.sv
module str_upcase_fsm
  import str_upcase_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   mem_rdy_i,
  input  logic   is_term_i,
  input  logic   is_lower_i,
  output state_e state_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i) state_d = ST_READ;
      ST_READ:          if (mem_rdy_i) state_d = ST_CHECK;
      ST_CHECK:         state_d = is_term_i ? ST_DONE : (is_lower_i ? ST_WRITE : ST_READ);
      ST_WRITE:         if (mem_rdy_i) state_d = ST_READ;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  assign state_o = state_q;
endmodule

// File: rtl/str_upcase.sv
module str_upcase
  import str_upcase_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  output logic          done_o,
  output logic [CW-1:0] count_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  input  logic          mem_rdy_i
);
  state_e          state;
  logic [AW-1:0]   addr_q;
  logic [CW-1:0]   cnt_q;
  logic [7:0]      byte_q;
  logic            is_term, is_lower;
  logic [7:0]      upper;

  str_upcase_classify u_cls (
    .byte_i    (byte_q),
    .is_term_o (is_term),
    .is_lower_o(is_lower),
    .upper_o   (upper)
  );

  str_upcase_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .mem_rdy_i (mem_rdy_i),
    .is_term_i (is_term),
    .is_lower_i(is_lower),
    .state_o   (state)
  );

  wire idle_like = (state == ST_IDLE) || (state == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
      byte_q <= '0;
    end else begin
      if (idle_like && start_i) begin
        addr_q <= base_i;
        cnt_q  <= '0;
      end
      if (state == ST_READ && mem_rdy_i) begin
        byte_q <= mem_rdata_i;
        cnt_q  <= cnt_q + 1'b1;
      end
      // advance once the byte is settled: no write needed, or write accepted
      if ((state == ST_CHECK && !is_term && !is_lower) ||
          (state == ST_WRITE && mem_rdy_i))
        addr_q <= addr_q + 1'b1;
    end
  end

  assign mem_req_o   = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we_o    = (state == ST_WRITE);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = (state == ST_WRITE) ? upper : 8'h00;
  assign done_o      = (state == ST_DONE);
  assign count_o     = cnt_q;

  // R9
  property stall_hold_p;
    @(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));
  endproperty
  stall_hold_chk: assert property (stall_hold_p);

  // R3
  property write_upper_p;
    @(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && mem_we_o) |-> (mem_wdata_o >= 8'h41 && mem_wdata_o <= 8'h5A);
  endproperty
  write_upper_chk: assert property (write_upper_p);

  // R7
  property done_hold_p;
    @(posedge clk_i) disable iff (!rst_ni)
      (done_o && !start_i) |=> done_o;
  endproperty
  done_hold_chk: assert property (done_hold_p);

  // R2
  property addr_step_p;
    @(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && mem_rdy_i && !done_o) |=> (mem_addr_o == $past(mem_addr_o) || mem_addr_o == $past(mem_addr_o) + 1'b1);
  endproperty
  addr_step_chk: assert property (addr_step_p);

  // R5
  property no_req_done_p;
    @(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !mem_req_o;
  endproperty
  no_req_done_chk: assert property (no_req_done_p);
endmodule

// File: tb/str_upcase_tb.sv
module str_upcase_tb;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int MS = 1024;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] base = 0;
  logic done, req, we, rdy;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr;
  logic [7:0] wdata, rdata;

  logic [7:0] mem [MS];
  logic [7:0] exp_mem [MS];
  int n_chk = 0, n_fail = 0;
  int writes = 0;
  int stall_pct = 0;
  int bad_write = 0;
  logic [AW-1:0] exp_addr;
  int addr_err = 0;

  always #2.5 clk = ~clk;

  str_upcase #(.AW(AW), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base),
    .done_o(done), .count_o(cnt), .mem_req_o(req), .mem_we_o(we),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata), .mem_rdy_i(rdy)
  );

  assign rdata = mem[addr % MS];

  always @(negedge clk) rdy <= ($urandom % 100) >= stall_pct;

  always @(posedge clk) if (rst_n && req && rdy) begin
    if (we) begin
      writes++;
      if (!(mem[addr%MS] >= 8'h61 && mem[addr%MS] <= 8'h7A)) bad_write++;
      mem[addr % MS] <= wdata;
    end else begin
      if (addr != exp_addr) addr_err++;
      exp_addr <= addr + 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req_s, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req_s, act, expv);
    end
  endtask

  task automatic run(input logic [AW-1:0] b, input int len);
    int cyc = 0;
    writes = 0; bad_write = 0; addr_err = 0; exp_addr = b;
    @(negedge clk); base = b; start = 1;
    @(negedge clk); start = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(done, "R7", done, 1);
    chk(cnt == len + 1, "R6", cnt, len + 1);
    chk(addr_err == 0, "R2", addr_err, 0);
    chk(bad_write == 0, "R4", bad_write, 0);
    for (int i = 0; i < MS; i++)
      if (mem[i] != exp_mem[i]) begin
        chk(0, "R3", mem[i], exp_mem[i]);
        break;
      end
  endtask

  function automatic logic [7:0] up(input logic [7:0] c);
    return (c >= 8'h61 && c <= 8'h7A) ? (c & 8'hDF) : c;
  endfunction

  initial begin
    for (int i = 0; i < MS; i++) begin mem[i] = 8'hEE; exp_mem[i] = 8'hEE; end
    rdy = 1;
    #1;
    chk(!done && !req && !we && cnt == 0, "R1", {done, req, we}, 0);
    #10 rst_n = 1;

    // empty string: R5
    mem[10] = 0; exp_mem[10] = 0;
    run(10, 0);
    chk(writes == 0, "R5", writes, 0);
    chk(mem[10] == 0, "R5", mem[10], 0);

    // all nonzero byte values 1..255 then terminator, no stalls
    for (int i = 1; i < 256; i++) begin mem[100+i-1] = i[7:0]; exp_mem[100+i-1] = up(i[7:0]); end
    mem[355] = 0; exp_mem[355] = 0;
    run(100, 255);
    chk(writes == 26, "R3", writes, 26);

    // R7: done holds
    repeat (20) @(negedge clk);
    chk(done, "R7", done, 1);

    // boundaries with stalls
    stall_pct = 60;
    begin
      logic [7:0] s [8] = '{8'h60, 8'h61, 8'h7A, 8'h7B, 8'h41, 8'h30, 8'hE1, 8'h7A};
      for (int i = 0; i < 8; i++) begin mem[400+i] = s[i]; exp_mem[400+i] = up(s[i]); end
      mem[408] = 0; exp_mem[408] = 0;
      run(400, 8);
      chk(writes == 3, "R4", writes, 3);
    end

    // random strings with stalls, R8 start mid-walk
    for (int t = 0; t < 6; t++) begin
      int len = 1 + ($urandom % 40);
      int b = 500 + t * 60;
      for (int i = 0; i < len; i++) begin
        logic [7:0] c = 8'h20 + 8'($urandom % 95);
        mem[b+i] = c; exp_mem[b+i] = up(c);
      end
      mem[b+len] = 0; exp_mem[b+len] = 0;
      if (t == 3) begin
        int cyc = 0;
        writes = 0; bad_write = 0; addr_err = 0; exp_addr = b[AW-1:0];
        @(negedge clk); base = b[AW-1:0]; start = 1;
        @(negedge clk); start = 0;
        repeat (3) @(negedge clk);
        base = 16'd5; start = 1; @(negedge clk); start = 0;
        while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
        chk(cnt == len + 1, "R8", cnt, len + 1);
        chk(addr_err == 0, "R8", addr_err, 0);
      end else run(b[AW-1:0], len);
    end
    chk(mem[5] == 8'hEE, "R8", mem[5], 8'hEE);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #900000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule